// File: doc/BRIEF.md
# Transmit De-emphasis Level Controller

This block sits between a serial bit source and the analog output driver of a long-cable link. It picks a drive amplitude for every outgoing bit. A bit that differs from the bit sent before it is driven at full swing. A bit that repeats its predecessor is driven at a lower, programmable level, which limits the charge that builds up on the cable during long runs of equal bits. As soon as the opposite value appears again, the swing returns to full, so a lone transition after a long run still opens the eye.

A boost setting doubles the nominal swing for long cables, and the reduced level is scaled by the same factor. Both settings are held in shadow registers. The shadow registers load only on a frame-start strobe, so a change to the configuration never alters the middle of a frame. Each valid input bit produces one output word, which holds the bit polarity and a 5-bit amplitude code, one clock later.

Top module: `tx_deemph_ctrl`

## Requirements
- R1: A valid bit whose value differs from the previous valid bit is sent with amplitude code 16, or with code 31 when boost is active.
- R2: A valid bit equal to the previous valid bit is sent with code 16 minus the active de-emphasis level L (0 to 7), or with min(31, 2*(16-L)) when boost is active. Level 0 therefore gives full swing.
- R3: After a run of any length, the first bit of the opposite value returns to full swing (16, or 31 with boost).
- R4: With boost active, full swing is code 31, the saturated value of the doubled nominal 16.
- R5: The first valid bit after reset is always sent at full swing, whatever its value.
- R6: cfg_level and cfg_boost are captured only in a cycle where frame_start is 1. The captured values apply to the bit presented in that same cycle and to every later bit until the next frame_start. Changes to the configuration inputs at other times have no effect.
- R7: out_valid is 1 exactly one cycle after a cycle with bit_valid set to 1, and out_pol then equals that bit. A cycle with no valid bit produces out_valid equal to 0.
- R8: While reset is asserted, out_valid, out_pol and out_amp are all 0, and the captured level and boost return to 0.
- R9: Cycles without a valid bit do not change the bit history. The next valid bit is compared with the last valid bit that came before the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | bit_in carries a bit to send this cycle |
| bit_in | input | 1 | Serial bit value |
| frame_start | input | 1 | Frame boundary strobe, which loads the configuration |
| cfg_level | input | 3 | De-emphasis level, in steps of 1/16 of full scale |
| cfg_boost | input | 1 | Double the nominal swing |
| out_valid | output | 1 | out_pol and out_amp carry a new bit |
| out_pol | output | 1 | Polarity of the bit to drive |
| out_amp | output | 5 | Drive amplitude code |

## Verification
The frame-start configuration load and the amplitude decision for a bit can fall in the same cycle. In that case, the bit in that cycle must already use the newly captured level and boost. The bench provokes this by sending frame_start together with a repeated bit while the configuration inputs hold a different level and boost from those in force. It also changes the configuration inputs between frame starts, where they must have no effect. A behavioural model that captures the configuration at the same edge it computes the expected code judges every output word, including those that follow gaps and very long runs.

// File: rtl/tx_deemph_ctrl.sv
module tx_deemph_ctrl #(
  parameter int LVL_W = 3,
  parameter int AMP_W = 5,
  parameter int UNIT  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             frame_start,
  input  logic [LVL_W-1:0] cfg_level,
  input  logic             cfg_boost,
  output logic             out_valid,
  output logic             out_pol,
  output logic [AMP_W-1:0] out_amp
);

  localparam int SW = AMP_W + 2;
  localparam logic [SW-1:0] UNIT_V  = SW'(UNIT);
  localparam logic [SW-1:0] AMP_MAX = SW'((1 << AMP_W) - 1);

  logic [LVL_W-1:0] lvl_q;
  logic             boost_q;
  logic             prev_q;
  logic             first_q;

  wire [LVL_W-1:0] lvl   = frame_start ? cfg_level : lvl_q;
  wire             boost = frame_start ? cfg_boost : boost_q;
  wire             rep   = !first_q && (bit_in == prev_q);

  wire [SW-1:0] base   = rep ? UNIT_V - SW'(lvl) : UNIT_V;
  wire [SW-1:0] scaled = boost ? (base << 1) : base;
  wire [AMP_W-1:0] amp = (scaled > AMP_MAX) ? AMP_MAX[AMP_W-1:0] : scaled[AMP_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      boost_q <= 1'b0;
    end else if (frame_start) begin
      lvl_q   <= cfg_level;
      boost_q <= cfg_boost;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      first_q <= 1'b1;
    end else if (bit_valid) begin
      prev_q  <= bit_in;
      first_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pol   <= 1'b0;
      out_amp   <= '0;
    end else begin
      out_valid <= bit_valid;
      if (bit_valid) begin
        out_pol <= bit_in;
        out_amp <= amp;
      end
    end
  end

endmodule

// File: rtl/tx_deemph_ctrl_chk.sv
module tx_deemph_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_valid,
  input logic       bit_in,
  input logic       frame_start,
  input logic       out_valid,
  input logic       out_pol,
  input logic [4:0] out_amp
);

  logic       seen, last_pol, last_rep, fs_acc, fs_bit;
  logic [4:0] last_amp;

  wire is_full = (out_amp == 5'd16) || (out_amp == 5'd31);
  wire rep_now = seen && (out_pol == last_pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0; last_pol <= 1'b0; last_rep <= 1'b0; last_amp <= '0;
      fs_acc <= 1'b0; fs_bit <= 1'b0;
    end else begin
      fs_acc <= bit_valid ? 1'b0 : (fs_acc | frame_start);
      fs_bit <= bit_valid & (fs_acc | frame_start);
      if (out_valid) begin
        seen <= 1'b1; last_pol <= out_pol; last_rep <= rep_now; last_amp <= out_amp;
      end
    end
  end

  assert_edge_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && seen && (out_pol != last_pol) |-> is_full);

  assert_rep_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && rep_now |-> (out_amp >= 5'd9));

  assert_first_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !seen |-> is_full);

  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && rep_now && last_rep && !fs_bit |-> (out_amp == last_amp));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> out_valid && (out_pol == $past(bit_in)));

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> !out_valid);

endmodule

bind tx_deemph_ctrl tx_deemph_ctrl_chk u_chk (.*);

// File: tb/tx_deemph_ctrl_bench.sv
module tx_deemph_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bit_valid = 0, bit_in = 0, frame_start = 0, cfg_boost = 0;
  logic [2:0] cfg_level = 0;
  logic out_valid, out_pol;
  logic [4:0] out_amp;

  tx_deemph_ctrl u_tx_deemph_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  bit started = 0, done = 0;

  int m_lvl, m_bst, m_prev, m_first, m_run, m_gap;
  int e_v, e_pol, e_amp;
  string e_tag;

  function automatic int amp_of(int rep, int lvl, int bst);
    int r;
    r = rep ? 16 - lvl : 16;
    if (bst) r = (2 * r > 31) ? 31 : 2 * r;
    return r;
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (!rst_n) begin
      m_lvl = 0; m_bst = 0; m_prev = 0; m_first = 1; m_run = 0; m_gap = 0;
      e_v = 0; e_pol = 0; e_amp = 0; e_tag = "R8";
    end else begin
      if (frame_start) begin m_lvl = cfg_level; m_bst = cfg_boost; end
      e_v = bit_valid;
      if (!bit_valid) begin
        e_tag = "R7"; m_gap = 1;
      end else begin
        int rep;
        rep = !m_first && (bit_in == m_prev);
        e_pol = bit_in;
        e_amp = amp_of(rep, m_lvl, m_bst);
        if (m_first) e_tag = "R5";
        else if (m_gap) e_tag = "R9";
        else if (frame_start) e_tag = "R6";
        else if (!rep && m_run >= 8) e_tag = "R3";
        else if (!rep && m_bst != 0) e_tag = "R4";
        else if (!rep) e_tag = "R1";
        else e_tag = "R2";
        m_run = rep ? m_run + 1 : 1;
        m_prev = bit_in; m_first = 0; m_gap = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (out_valid !== e_v[0] || (e_v != 0 && (out_pol !== e_pol[0] || out_amp !== e_amp[4:0]))) begin
        failures++;
        $display("FAIL %s: valid/pol/amp actual %0b/%0b/%0d expected %0d/%0d/%0d",
                 e_tag, out_valid, out_pol, out_amp, e_v, e_pol, e_amp);
      end
    end
  end

  task automatic cyc(input bit v, input bit b, input bit fs);
    bit_valid = v; bit_in = b; frame_start = fs;
    @(negedge clk);
  endtask

  task automatic set_cfg(input int lvl, input bit bst);
    cfg_level = 3'(lvl); cfg_boost = bst;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R5: first bit after reset is a 0 (matches reset history value)
    cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 1, 0); cyc(1, 1, 0);
    // R6: cfg change without frame_start has no effect
    set_cfg(5, 1); cyc(1, 1, 0); cyc(1, 1, 0);
    // R6: frame_start coincides with a repeated bit
    cyc(1, 1, 1); cyc(1, 1, 0); set_cfg(0, 0); cyc(1, 1, 0);
    // R3: long run then opposite bit
    for (int i = 0; i < 20; i++) cyc(1, 1, 0);
    cyc(1, 0, 0); cyc(1, 0, 0);
    // R9: gaps keep history
    cyc(0, 1, 0); cyc(0, 0, 0); cyc(1, 0, 0); cyc(0, 0, 0); cyc(1, 1, 0);
    // R2/R4: all levels with and without boost
    for (int l = 0; l < 8; l++) begin
      for (int bst = 0; bst < 2; bst++) begin
        set_cfg(l, bst[0]); cyc(0, 0, 1); set_cfg(7 - l, ~bst[0]);
        cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 1, 0); cyc(1, 1, 0);
      end
    end
    // R5 with bit 1 after mid-run reset
    rst_n = 0; cyc(0, 0, 0); cyc(0, 0, 0); rst_n = 1;
    cyc(1, 1, 0); cyc(1, 1, 0);
    rst_n = 0; cyc(0, 0, 0); rst_n = 1;
    cyc(1, 0, 0); cyc(1, 0, 0);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      set_cfg($urandom_range(0, 7), 1'($urandom_range(0, 1)));
      cyc(1'($urandom_range(0, 4) != 0), 1'($urandom_range(0, 3) == 0 ? ~bit_in : bit_in),
          1'($urandom_range(0, 15) == 0));
    end
    cyc(0, 0, 0); cyc(0, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL R7: watchdog actual %0d cycles expected completion", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule